// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside a CPU pipeline and turns a single request for a general exception, a trap, a TLB fault, a TLB multi-hit, an external interrupt or a reset into the complete set of architectural state updates that enter the handler. The pipeline presents the kind of request, an event code, the trap immediate, the faulting virtual address and a snapshot of the current PC, the next PC, the merged status register, R15, the vector base and the low bits of the page-table-entry-high register. One clock later the block presents the handler PC, the following PC, the new status register, and write strobes with data for the shadow registers (saved SR, saved PC, saved R15) and for the event registers: exception event, interrupt event, trap, TLB fault address and page-table-entry-high.

A general exception raised while the block bit is already set does not enter a handler. It is turned into a manual reset. A power-on reset request and a TLB multi-hit also take the reset path: the vector base is cleared, the PC goes to the fixed boot address and the interrupt mask is raised to its maximum. Every other kind vectors relative to the vector base, with a different offset for general exceptions and traps, TLB faults and interrupts. Pipeline flush and choosing between competing interrupts are done elsewhere.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset release, and in any cycle that follows a cycle with req_valid low, ent_valid is low. A request with req_valid high and a known kind gives ent_valid high for exactly the next cycle. sr_we and delay_clr equal ent_valid.
- R2: A general exception (req_kind 0) with cur_sr bit 28 (block) clear gives pc_out = cur_vbr + 0x100. It gives save_we with ssr_out = cur_sr, spc_out = cur_pc and sgr_out = cur_r15. expevt_out = req_code, and sr_out = cur_sr with bits 30 (privileged), 29 (bank) and 28 (block) set.
- R3: A general exception with cur_sr bit 28 set escalates to a manual reset. vbr_clr is asserted, pc_out = 0xA0000000 and expevt_out = 0x020. sr_out = cur_sr with bits 30, 29, 28 and 7:4 (interrupt mask) set and bit 15 (FPU disable) cleared. save_we stays low.
- R4: A reset request (req_kind 5) behaves as R3, except that expevt_out = req_code.
- R5: A trap (req_kind 1) gives tra_out = trap_imm shifted left by 2 and zero-extended, and expevt_out = 0x160. Vector, saves and SR are as in R2, whatever the block bit.
- R6: A TLB fault (req_kind 2) gives tea_out = fault_vpn and pteh_out = {fault_vpn[31:10], pteh_keep}. It gives expevt_out = req_code and pc_out = cur_vbr + 0x400. Saves and SR are as in R2.
- R7: A TLB multi-hit (req_kind 3) writes tea_out and pteh_out as in R6 and otherwise follows R4.
- R8: An interrupt (req_kind 4) gives intevt_out = req_code and pc_out = cur_vbr + 0x600, with spc_out = cur_next_pc. Exception event is not written, and SR and the other saves are as in R2.
- R9: On every entry new_pc_out = pc_out + 2 and delay_clr is high.
- R10: Each kind asserts exactly this set of strobes. General and trap: save_we and expevt_we, plus tra_we for a trap. TLB fault: save_we, expevt_we, tea_we and pteh_we. Multi-hit: vbr_clr, expevt_we, tea_we and pteh_we. Interrupt: save_we and intevt_we. Reset and escalated general: vbr_clr and expevt_we.
- R11: req_kind values 6 and 7 are ignored. No entry follows and no strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Entry request present this cycle |
| req_kind | input | 3 | 0 general, 1 trap, 2 TLB fault, 3 multi-hit, 4 interrupt, 5 reset |
| req_code | input | CODE_W | Event code for the request |
| trap_imm | input | IMM_W | Trap immediate |
| fault_vpn | input | XLEN | Faulting virtual address |
| cur_pc | input | XLEN | PC of the faulting instruction |
| cur_next_pc | input | XLEN | PC of the next instruction |
| cur_sr | input | XLEN | Current merged status register |
| cur_r15 | input | XLEN | Current stack register |
| cur_vbr | input | XLEN | Current vector base |
| pteh_keep | input | PAGE_LSB | Low bits of the page-table-entry-high register |
| ent_valid | output | 1 | Entry performed |
| pc_out | output | XLEN | Handler PC |
| new_pc_out | output | XLEN | PC following the handler PC |
| sr_we | output | 1 | Status register write |
| sr_out | output | XLEN | New status register |
| delay_clr | output | 1 | Clear delay-slot flag |
| save_we | output | 1 | Write saved SR, saved PC and saved R15 |
| ssr_out | output | XLEN | Saved SR value |
| spc_out | output | XLEN | Saved PC value |
| sgr_out | output | XLEN | Saved R15 value |
| vbr_clr | output | 1 | Clear vector base |
| expevt_we | output | 1 | Exception event register write |
| expevt_out | output | CODE_W | Exception event value |
| intevt_we | output | 1 | Interrupt event register write |
| intevt_out | output | CODE_W | Interrupt event value |
| tra_we | output | 1 | Trap register write |
| tra_out | output | XLEN | Trap register value |
| tea_we | output | 1 | TLB fault address write |
| tea_out | output | XLEN | TLB fault address value |
| pteh_we | output | 1 | Page-table-entry-high write |
| pteh_out | output | XLEN | Page-table-entry-high value |

## Verification
The embedded properties check these on every cycle:
- the one-cycle entry pulse and the silence of all strobes outside an entry;
- the privileged, blocked, bank-1 SR;
- the +2 follow-on PC;
- the boot PC, mask and FPU-disable state whenever the vector base is cleared;
- escalation of a blocked general exception;
- the pairing of fault address and page-table writes;
- the two-bit alignment of the trap value.

Only the bench's sweep over every kind, both block-bit states and several operand patterns can show the exact vector offsets, the saved-PC choice, the event code selected per kind and the exact strobe set of each kind. The same holds for the full trap-immediate range and the walking-bit fault addresses that show which bits of the page-table value are kept.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    EK_GENERAL  = 3'd0,
    EK_TRAP     = 3'd1,
    EK_TLB      = 3'd2,
    EK_MULTIHIT = 3'd3,
    EK_IRQ      = 3'd4,
    EK_RESET    = 3'd5
  } entry_kind_e;

  typedef enum logic [1:0] {
    VS_BOOT    = 2'd0,
    VS_GENERAL = 2'd1,
    VS_TLB     = 2'd2,
    VS_IRQ     = 2'd3
  } vec_sel_e;

  // status register bit positions decoded by the core
  localparam int SR_MD_BIT    = 30;
  localparam int SR_RB_BIT    = 29;
  localparam int SR_BL_BIT    = 28;
  localparam int SR_FD_BIT    = 15;
  localparam int SR_IMASK_LSB = 4;
  localparam int SR_IMASK_W   = 4;

  typedef struct packed {
    logic     take;
    logic     boot;
    logic     manual;
    logic     save;
    logic     wr_expevt;
    logic     wr_intevt;
    logic     wr_tra;
    logic     wr_tlb;
    logic     spc_next;
    vec_sel_e vec;
  } entry_plan_t;

endpackage

// File: rtl/exc_entry_classify.sv
module exc_entry_classify
  import exc_entry_pkg::*;
(
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic        blocked,
  output entry_plan_t plan
);

  always_comb begin
    plan.take      = 1'b0;
    plan.boot      = 1'b0;
    plan.manual    = 1'b0;
    plan.save      = 1'b0;
    plan.wr_expevt = 1'b0;
    plan.wr_intevt = 1'b0;
    plan.wr_tra    = 1'b0;
    plan.wr_tlb    = 1'b0;
    plan.spc_next  = 1'b0;
    plan.vec       = VS_BOOT;
    if (req_valid) begin
      case (req_kind)
        EK_GENERAL: begin
          plan.take      = 1'b1;
          plan.wr_expevt = 1'b1;
          if (blocked) begin
            plan.boot   = 1'b1;
            plan.manual = 1'b1;
            plan.vec    = VS_BOOT;
          end else begin
            plan.save = 1'b1;
            plan.vec  = VS_GENERAL;
          end
        end
        EK_TRAP: begin
          plan.take      = 1'b1;
          plan.save      = 1'b1;
          plan.wr_expevt = 1'b1;
          plan.wr_tra    = 1'b1;
          plan.vec       = VS_GENERAL;
        end
        EK_TLB: begin
          plan.take      = 1'b1;
          plan.save      = 1'b1;
          plan.wr_expevt = 1'b1;
          plan.wr_tlb    = 1'b1;
          plan.vec       = VS_TLB;
        end
        EK_MULTIHIT: begin
          plan.take      = 1'b1;
          plan.boot      = 1'b1;
          plan.wr_expevt = 1'b1;
          plan.wr_tlb    = 1'b1;
          plan.vec       = VS_BOOT;
        end
        EK_IRQ: begin
          plan.take      = 1'b1;
          plan.save      = 1'b1;
          plan.wr_intevt = 1'b1;
          plan.spc_next  = 1'b1;
          plan.vec       = VS_IRQ;
        end
        EK_RESET: begin
          plan.take      = 1'b1;
          plan.boot      = 1'b1;
          plan.wr_expevt = 1'b1;
          plan.vec       = VS_BOOT;
        end
        default: begin
          plan.take = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/exc_entry_vector.sv
module exc_entry_vector
  import exc_entry_pkg::*;
#(
  parameter int               XLEN     = 32,
  parameter logic [XLEN-1:0]  RESET_PC = 32'hA000_0000,
  parameter logic [XLEN-1:0]  VEC_GEN  = 32'h0000_0100,
  parameter logic [XLEN-1:0]  VEC_TLB  = 32'h0000_0400,
  parameter logic [XLEN-1:0]  VEC_IRQ  = 32'h0000_0600
) (
  input  vec_sel_e        vec,
  input  logic [XLEN-1:0] vbr,
  output logic [XLEN-1:0] pc_new,
  output logic [XLEN-1:0] pc_follow
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);

  logic [XLEN-1:0] offset;

  always_comb begin
    case (vec)
      VS_TLB:  offset = VEC_TLB;
      VS_IRQ:  offset = VEC_IRQ;
      default: offset = VEC_GEN;
    endcase
  end

  always_comb begin
    if (vec == VS_BOOT) pc_new = RESET_PC;
    else                pc_new = vbr + offset;
    pc_follow = pc_new + INSN_BYTES;
  end

endmodule

// File: rtl/exc_entry_sr.sv
module exc_entry_sr
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_sr,
  input  logic            boot,
  output logic [XLEN-1:0] sr_new
);

  localparam logic [XLEN-1:0] PRIV_SET =
    (XLEN'(1) << SR_MD_BIT) | (XLEN'(1) << SR_RB_BIT) | (XLEN'(1) << SR_BL_BIT);
  localparam logic [XLEN-1:0] MASK_SET =
    XLEN'(((1 << SR_IMASK_W) - 1) << SR_IMASK_LSB);
  localparam logic [XLEN-1:0] FD_CLR = ~(XLEN'(1) << SR_FD_BIT);

  always_comb begin
    sr_new = cur_sr | PRIV_SET;
    if (boot) sr_new = (sr_new | MASK_SET) & FD_CLR;
  end

endmodule

// File: rtl/exc_entry_evtregs.sv
module exc_entry_evtregs #(
  parameter int                XLEN        = 32,
  parameter int                CODE_W      = 12,
  parameter int                IMM_W       = 8,
  parameter int                PAGE_LSB    = 10,
  parameter logic [CODE_W-1:0] TRAP_CODE   = 12'h160,
  parameter logic [CODE_W-1:0] MANUAL_CODE = 12'h020
) (
  input  logic                manual,
  input  logic                is_trap,
  input  logic [CODE_W-1:0]   req_code,
  input  logic [IMM_W-1:0]    trap_imm,
  input  logic [XLEN-1:0]     fault_vpn,
  input  logic [PAGE_LSB-1:0] pteh_keep,
  output logic [CODE_W-1:0]   expevt_val,
  output logic [XLEN-1:0]     tra_val,
  output logic [XLEN-1:0]     pteh_val
);

  localparam int TRA_PAD = XLEN - IMM_W - 2;

  always_comb begin
    if (manual)       expevt_val = MANUAL_CODE;
    else if (is_trap) expevt_val = TRAP_CODE;
    else              expevt_val = req_code;
    tra_val  = {{TRA_PAD{1'b0}}, trap_imm, 2'b00};
    pteh_val = {fault_vpn[XLEN-1:PAGE_LSB], pteh_keep};
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int                XLEN        = 32,
  parameter int                CODE_W      = 12,
  parameter int                IMM_W       = 8,
  parameter int                PAGE_LSB    = 10,
  parameter logic [XLEN-1:0]   RESET_PC    = 32'hA000_0000,
  parameter logic [XLEN-1:0]   VEC_GEN     = 32'h0000_0100,
  parameter logic [XLEN-1:0]   VEC_TLB     = 32'h0000_0400,
  parameter logic [XLEN-1:0]   VEC_IRQ     = 32'h0000_0600,
  parameter logic [CODE_W-1:0] TRAP_CODE   = 12'h160,
  parameter logic [CODE_W-1:0] MANUAL_CODE = 12'h020
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_kind,
  input  logic [CODE_W-1:0]   req_code,
  input  logic [IMM_W-1:0]    trap_imm,
  input  logic [XLEN-1:0]     fault_vpn,
  input  logic [XLEN-1:0]     cur_pc,
  input  logic [XLEN-1:0]     cur_next_pc,
  input  logic [XLEN-1:0]     cur_sr,
  input  logic [XLEN-1:0]     cur_r15,
  input  logic [XLEN-1:0]     cur_vbr,
  input  logic [PAGE_LSB-1:0] pteh_keep,
  output logic                ent_valid,
  output logic [XLEN-1:0]     pc_out,
  output logic [XLEN-1:0]     new_pc_out,
  output logic                sr_we,
  output logic [XLEN-1:0]     sr_out,
  output logic                delay_clr,
  output logic                save_we,
  output logic [XLEN-1:0]     ssr_out,
  output logic [XLEN-1:0]     spc_out,
  output logic [XLEN-1:0]     sgr_out,
  output logic                vbr_clr,
  output logic                expevt_we,
  output logic [CODE_W-1:0]   expevt_out,
  output logic                intevt_we,
  output logic [CODE_W-1:0]   intevt_out,
  output logic                tra_we,
  output logic [XLEN-1:0]     tra_out,
  output logic                tea_we,
  output logic [XLEN-1:0]     tea_out,
  output logic                pteh_we,
  output logic [XLEN-1:0]     pteh_out
);

  localparam int RST_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[RST_STAGES-1];

  // decode and datapath
  entry_plan_t       plan;
  logic [XLEN-1:0]   pc_new, pc_follow, sr_new, tra_val, pteh_val;
  logic [CODE_W-1:0] expevt_val;

  exc_entry_classify u_classify (
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .blocked   (cur_sr[SR_BL_BIT]),
    .plan      (plan)
  );

  exc_entry_vector #(
    .XLEN     (XLEN),
    .RESET_PC (RESET_PC),
    .VEC_GEN  (VEC_GEN),
    .VEC_TLB  (VEC_TLB),
    .VEC_IRQ  (VEC_IRQ)
  ) u_vector (
    .vec       (plan.vec),
    .vbr       (cur_vbr),
    .pc_new    (pc_new),
    .pc_follow (pc_follow)
  );

  exc_entry_sr #(.XLEN(XLEN)) u_sr (
    .cur_sr (cur_sr),
    .boot   (plan.boot),
    .sr_new (sr_new)
  );

  exc_entry_evtregs #(
    .XLEN        (XLEN),
    .CODE_W      (CODE_W),
    .IMM_W       (IMM_W),
    .PAGE_LSB    (PAGE_LSB),
    .TRAP_CODE   (TRAP_CODE),
    .MANUAL_CODE (MANUAL_CODE)
  ) u_evtregs (
    .manual     (plan.manual),
    .is_trap    (plan.wr_tra),
    .req_code   (req_code),
    .trap_imm   (trap_imm),
    .fault_vpn  (fault_vpn),
    .pteh_keep  (pteh_keep),
    .expevt_val (expevt_val),
    .tra_val    (tra_val),
    .pteh_val   (pteh_val)
  );

  // next state
  logic            ent_d, save_d, vbr_clr_d, expevt_d, intevt_d, tra_d, tlb_d;
  logic [XLEN-1:0] spc_d;

  always_comb begin
    ent_d     = plan.take;
    save_d    = plan.save;
    vbr_clr_d = plan.boot;
    expevt_d  = plan.wr_expevt;
    intevt_d  = plan.wr_intevt;
    tra_d     = plan.wr_tra;
    tlb_d     = plan.wr_tlb;
    spc_d     = plan.spc_next ? cur_next_pc : cur_pc;
  end

  // registers
  logic              ent_q, save_q, vbr_clr_q, expevt_q, intevt_q, tra_q, tlb_q;
  logic [XLEN-1:0]   pc_q, npc_q, sr_q, ssr_q, spc_q, sgr_q, tra_val_q, tea_q, pteh_q;
  logic [CODE_W-1:0] expevt_val_q, intevt_val_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ent_q        <= 1'b0;
      save_q       <= 1'b0;
      vbr_clr_q    <= 1'b0;
      expevt_q     <= 1'b0;
      intevt_q     <= 1'b0;
      tra_q        <= 1'b0;
      tlb_q        <= 1'b0;
      pc_q         <= '0;
      npc_q        <= '0;
      sr_q         <= '0;
      ssr_q        <= '0;
      spc_q        <= '0;
      sgr_q        <= '0;
      expevt_val_q <= '0;
      intevt_val_q <= '0;
      tra_val_q    <= '0;
      tea_q        <= '0;
      pteh_q       <= '0;
    end else begin
      ent_q     <= ent_d;
      save_q    <= save_d;
      vbr_clr_q <= vbr_clr_d;
      expevt_q  <= expevt_d;
      intevt_q  <= intevt_d;
      tra_q     <= tra_d;
      tlb_q     <= tlb_d;
      if (ent_d) begin
        pc_q  <= pc_new;
        npc_q <= pc_follow;
        sr_q  <= sr_new;
      end
      if (save_d) begin
        ssr_q <= cur_sr;
        spc_q <= spc_d;
        sgr_q <= cur_r15;
      end
      if (expevt_d) expevt_val_q <= expevt_val;
      if (intevt_d) intevt_val_q <= req_code;
      if (tra_d)    tra_val_q    <= tra_val;
      if (tlb_d) begin
        tea_q  <= fault_vpn;
        pteh_q <= pteh_val;
      end
    end
  end

  assign ent_valid  = ent_q;
  assign sr_we      = ent_q;
  assign delay_clr  = ent_q;
  assign pc_out     = pc_q;
  assign new_pc_out = npc_q;
  assign sr_out     = sr_q;
  assign save_we    = save_q;
  assign ssr_out    = ssr_q;
  assign spc_out    = spc_q;
  assign sgr_out    = sgr_q;
  assign vbr_clr    = vbr_clr_q;
  assign expevt_we  = expevt_q;
  assign expevt_out = expevt_val_q;
  assign intevt_we  = intevt_q;
  assign intevt_out = intevt_val_q;
  assign tra_we     = tra_q;
  assign tra_out    = tra_val_q;
  assign tea_we     = tlb_q;
  assign tea_out    = tea_q;
  assign pteh_we    = tlb_q;
  assign pteh_out   = pteh_q;

  // properties
  AST_IDLE_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> !ent_valid); // R1

  AST_QUIET_STROBES: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ent_valid |-> !(save_we || vbr_clr || expevt_we || intevt_we || tra_we || tea_we || pteh_we)); // R10

  AST_PRIV_SR: assert property (@(posedge clk) disable iff (!rst_q_n)
    ent_valid |-> (sr_out[SR_MD_BIT] && sr_out[SR_RB_BIT] && sr_out[SR_BL_BIT])); // R2

  AST_FOLLOW_PC: assert property (@(posedge clk) disable iff (!rst_q_n)
    ent_valid |-> (new_pc_out == pc_out + XLEN'(2)) && delay_clr); // R9

  AST_BOOT_STATE: assert property (@(posedge clk) disable iff (!rst_q_n)
    vbr_clr |-> (pc_out == RESET_PC) && (&sr_out[SR_IMASK_LSB +: SR_IMASK_W])
                && !sr_out[SR_FD_BIT] && !save_we); // R3

  AST_BL_ESCALATE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_kind == EK_GENERAL && cur_sr[SR_BL_BIT]) |=>
      (vbr_clr && expevt_we && expevt_out == MANUAL_CODE)); // R3

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_q_n)
    ent_valid |-> !(expevt_we && intevt_we)); // R8

  AST_TRA_ALIGNED: assert property (@(posedge clk) disable iff (!rst_q_n)
    tra_we |-> (tra_out[1:0] == 2'b00)); // R5

  AST_TLB_PAIR: assert property (@(posedge clk) disable iff (!rst_q_n)
    tea_we |-> pteh_we && (pteh_out[XLEN-1:PAGE_LSB] == tea_out[XLEN-1:PAGE_LSB])); // R6

  AST_UNKNOWN_KIND: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_kind > 3'd5) |=> !ent_valid); // R11

endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [11:0] req_code;
  logic [7:0]  trap_imm;
  logic [31:0] fault_vpn, cur_pc, cur_next_pc, cur_sr, cur_r15, cur_vbr;
  logic [9:0]  pteh_keep;
  logic        ent_valid, sr_we, delay_clr, save_we, vbr_clr, expevt_we, intevt_we;
  logic        tra_we, tea_we, pteh_we;
  logic [31:0] pc_out, new_pc_out, sr_out, ssr_out, spc_out, sgr_out, tra_out, tea_out, pteh_out;
  logic [11:0] expevt_out, intevt_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_code(req_code), .trap_imm(trap_imm), .fault_vpn(fault_vpn),
    .cur_pc(cur_pc), .cur_next_pc(cur_next_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
    .cur_vbr(cur_vbr), .pteh_keep(pteh_keep),
    .ent_valid(ent_valid), .pc_out(pc_out), .new_pc_out(new_pc_out), .sr_we(sr_we),
    .sr_out(sr_out), .delay_clr(delay_clr), .save_we(save_we), .ssr_out(ssr_out),
    .spc_out(spc_out), .sgr_out(sgr_out), .vbr_clr(vbr_clr), .expevt_we(expevt_we),
    .expevt_out(expevt_out), .intevt_we(intevt_we), .intevt_out(intevt_out),
    .tra_we(tra_we), .tra_out(tra_out), .tea_we(tea_we), .tea_out(tea_out),
    .pteh_we(pteh_we), .pteh_out(pteh_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic strobes_quiet(input string tag);
    chk({tag, " ent_valid"}, {31'd0, ent_valid}, 32'd0);
    chk({tag, " strobes"},
        {25'd0, save_we, vbr_clr, expevt_we, intevt_we, tra_we, tea_we, pteh_we}, 32'd0);
  endtask

  // one request, then one idle cycle; starts and ends just after a falling edge
  task automatic run_entry(input int kind, input int bl, input int p);
    logic [31:0] vbr, sr, pc, npc, r15, vpn, e_pc, e_sr;
    logic [11:0] code, e_exp;
    logic [7:0]  imm;
    logic [9:0]  keep;
    bit boot, known, e_save, e_exw, e_inw, e_tra, e_tlb;
    string rt;
    vbr  = 32'h8C00_0000 + 32'(p) * 32'h0002_0000;
    sr   = 32'h0000_8003 ^ (32'(p) * 32'h0101_0010);
    sr   = bl ? (sr | 32'h1000_0000) : (sr & ~32'h1000_0000);
    pc   = 32'h8C01_0000 + 32'(p) * 6;
    npc  = pc + 32'h10;
    r15  = 32'h7FF0_0000 - 32'(p);
    code = 12'h0A0 + 12'(p * 32);
    imm  = 8'h3C + 8'(p);
    vpn  = 32'hC0DE_1234 + 32'(p) * 32'h0001_0400;
    keep = 10'h2A5 ^ 10'(p);

    known = (kind <= 5);
    boot  = (kind == 5) || (kind == 3) || (kind == 0 && bl != 0);
    case (kind)
      0: rt = bl ? "R3" : "R2";
      1: rt = "R5";
      2: rt = "R6";
      3: rt = "R7";
      4: rt = "R8";
      5: rt = "R4";
      default: rt = "R11";
    endcase
    if (boot)           e_pc = 32'hA000_0000;
    else if (kind == 2) e_pc = vbr + 32'h400;
    else if (kind == 4) e_pc = vbr + 32'h600;
    else                e_pc = vbr + 32'h100;
    e_sr = sr | 32'h7000_0000;
    if (boot) e_sr = (e_sr | 32'h0000_00F0) & ~32'h0000_8000;
    if (kind == 0 && bl != 0) e_exp = 12'h020;
    else if (kind == 1)       e_exp = 12'h160;
    else                      e_exp = code;
    e_save = known && !boot;
    e_exw  = known && kind != 4;
    e_inw  = (kind == 4);
    e_tra  = (kind == 1);
    e_tlb  = (kind == 2) || (kind == 3);

    req_valid = 1'b1; req_kind = 3'(kind); req_code = code; trap_imm = imm;
    fault_vpn = vpn; cur_pc = pc; cur_next_pc = npc; cur_sr = sr; cur_r15 = r15;
    cur_vbr = vbr; pteh_keep = keep;
    @(posedge clk); @(negedge clk);

    chk({"R1 ent_valid ", rt}, {31'd0, ent_valid}, {31'd0, known});
    chk({"R10 strobe set ", rt},
        {25'd0, save_we, vbr_clr, expevt_we, intevt_we, tra_we, tea_we, pteh_we},
        {25'd0, e_save, boot, e_exw, e_inw, e_tra, e_tlb, e_tlb});
    if (known) begin
      chk({rt, " pc"}, pc_out, e_pc);
      chk({rt, " sr"}, sr_out, e_sr);
      chk({"R9 new_pc ", rt}, new_pc_out, e_pc + 32'd2);
      chk({"R9 delay_clr ", rt}, {30'd0, delay_clr, sr_we}, 32'd3);
      if (e_save) begin
        chk({rt, " ssr"}, ssr_out, sr);
        chk({rt, " spc"}, spc_out, (kind == 4) ? npc : pc);
        chk({rt, " sgr"}, sgr_out, r15);
      end
      if (e_exw) chk({rt, " expevt"}, {20'd0, expevt_out}, {20'd0, e_exp});
      if (e_inw) chk({rt, " intevt"}, {20'd0, intevt_out}, {20'd0, code});
      if (e_tra) chk({rt, " tra"}, tra_out, {22'd0, imm, 2'b00});
      if (e_tlb) begin
        chk({rt, " tea"}, tea_out, vpn);
        chk({rt, " pteh"}, pteh_out, {vpn[31:10], keep});
      end
    end

    req_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    strobes_quiet("R1 after entry");
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_code = '0; trap_imm = '0;
    fault_vpn = '0; cur_pc = '0; cur_next_pc = '0; cur_sr = '0; cur_r15 = '0;
    cur_vbr = '0; pteh_keep = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strobes_quiet("R1 reset state");

    // every kind, both block-bit states, four operand patterns
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 4; p++)
          run_entry(k, b, p);

    // full trap immediate range
    for (int i = 0; i < 256; i++) begin
      req_valid = 1'b1; req_kind = 3'd1; trap_imm = 8'(i); cur_sr = 32'h0;
      @(posedge clk); @(negedge clk);
      chk("R5 tra sweep", tra_out, 32'(i) * 32'd4);
      chk("R5 expevt sweep", {20'd0, expevt_out}, 32'h160);
      req_valid = 1'b0;
    end

    // walking-one fault address, both TLB kinds
    for (int k = 2; k < 4; k++)
      for (int i = 0; i < 32; i++) begin
        req_valid = 1'b1; req_kind = 3'(k); fault_vpn = 32'd1 << i;
        pteh_keep = 10'h3FF;
        @(posedge clk); @(negedge clk);
        chk((k == 2) ? "R6 tea walk" : "R7 tea walk", tea_out, 32'd1 << i);
        chk((k == 2) ? "R6 pteh walk" : "R7 pteh walk", pteh_out,
            ((32'd1 << i) & 32'hFFFF_FC00) | 32'h3FF);
        req_valid = 1'b0;
      end

    @(posedge clk); @(negedge clk);
    strobes_quiet("R1 final idle");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule